// File: doc/BRIEF.md
# Adapter Command and Interrupt Controller

This block sits between a host bus and the internal engines of a network adapter. The host sends 16-bit command words. The top five bits of a word hold an opcode and the low eleven bits hold an argument. The host reads back one 16-bit status word. That word shows the active register window, a command-in-progress flag and eight latched interrupt causes. The block turns each accepted command into level enables or one-cycle reset pulses for the receiver and the transmitter. It also loads the receive filter code and manages two masks: one gates the interrupt output and the other hides status bits from reads.

Internal engines raise interrupt causes as one-cycle pulses on an eight-bit input. Each pulse sets the matching latched cause. A cause stays set until the host acknowledges it by writing a bit mask. A global reset command returns the controller to its power-up values. It then keeps the command-in-progress flag high for a parameter-set number of cycles. Any command written while that flag is high is dropped.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: After reset the status word is 0x0000, the interrupt output is low, the receiver and transmitter are disabled, no reset pulse is active and the filter code is 0. The interrupt mask resets to 0x00 and the read mask resets to 0xFF.
- R2: Opcode 1 loads argument bits 2..0 as the window number. The window number appears in status bits 15..13 one cycle after the command is accepted and holds until the next window select or global reset.
- R3: Causes latch into status bits 7..0. Bit n is set by a pulse on `causeIn[n]`, and the bits have these meanings: 0 latch, 1 failure, 2 transmit done, 3 transmit space, 4 receive done, 5 receive early, 6 host request, 7 statistics. Status bits 11..8 read 0 and bit 12 is the command-in-progress flag.
- R4: Opcode 13 clears each latched cause whose bit is set in argument bits 7..0. If a cause pulse and a clear for the same bit arrive in the same cycle, the bit stays set.
- R5: Opcode 14 loads the interrupt mask from argument bits 7..0. `intOut` is high exactly when some latched cause has its mask bit set.
- R6: Opcode 15 loads the read mask from argument bits 7..0. Status bits 7..0 show latched causes ANDed with this mask. The read mask does not change the latched causes or the interrupt output.
- R7: Opcode 4 enables the receiver and opcode 3 disables it. Opcode 5 drives `rxResetPulse` high for exactly one cycle and leaves the receiver disabled. For these commands the argument bits have no effect.
- R8: Opcode 9 enables the transmitter and opcode 10 disables it. Opcode 11 drives `txResetPulse` high for exactly one cycle and leaves the transmitter disabled.
- R9: Opcode 12 sets latched cause bit 6.
- R10: Opcode 16 loads argument bits 3..0 into `rxFilter`, with bit 0 individual, bit 1 group, bit 2 broadcast and bit 3 all frames. Argument bits 10..4 are ignored.
- R11: Opcode 0 restores every reset value of R1 except the window, which goes to 0. It pulses `globalResetPulse` for one cycle and holds status bit 12 high for RESET_CYCLES cycles.
- R12: Any other opcode changes no state and raises status bit 12 for one cycle. A command written while status bit 12 is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command write strobe |
| cmdWord | input | 16 | Opcode in bits 15..11, argument in bits 10..0 |
| causeIn | input | 8 | One-cycle interrupt cause pulses |
| statusWord | output | 16 | Window, busy flag and masked causes |
| intOut | output | 1 | Interrupt request to the host |
| rxEnabled | output | 1 | Receiver enable level |
| txEnabled | output | 1 | Transmitter enable level |
| rxResetPulse | output | 1 | One-cycle receiver reset |
| txResetPulse | output | 1 | One-cycle transmitter reset |
| globalResetPulse | output | 1 | One-cycle adapter-wide reset |
| rxFilter | output | 4 | Receive filter code |

## Verification
The bench builds the block with RESET_CYCLES set to 3. With that setting, the entire busy window after a global reset can be watched cycle by cycle, including a command dropped in the middle of it and the cycle where the flag falls. The one-cycle busy flag from an unknown opcode uses the same counter path. The bench can therefore show that a write landing on that single cycle is lost and that the window select it carried never happens.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int OPC_W   = 5;
  localparam int ARG_W   = 11;
  localparam int WIN_W   = 3;
  localparam int CAUSE_W = 8;
  localparam int FILT_W  = 4;
  localparam int REQ_BIT = 6;

  localparam logic [OPC_W-1:0] OP_GRESET   = 5'd0;
  localparam logic [OPC_W-1:0] OP_WINDOW   = 5'd1;
  localparam logic [OPC_W-1:0] OP_RX_OFF   = 5'd3;
  localparam logic [OPC_W-1:0] OP_RX_ON    = 5'd4;
  localparam logic [OPC_W-1:0] OP_RX_RST   = 5'd5;
  localparam logic [OPC_W-1:0] OP_TX_ON    = 5'd9;
  localparam logic [OPC_W-1:0] OP_TX_OFF   = 5'd10;
  localparam logic [OPC_W-1:0] OP_TX_RST   = 5'd11;
  localparam logic [OPC_W-1:0] OP_REQ_INT  = 5'd12;
  localparam logic [OPC_W-1:0] OP_ACK      = 5'd13;
  localparam logic [OPC_W-1:0] OP_INT_MASK = 5'd14;
  localparam logic [OPC_W-1:0] OP_RD_MASK  = 5'd15;
  localparam logic [OPC_W-1:0] OP_FILTER   = 5'd16;

  typedef struct packed {
    logic gReset;
    logic winLoad;
    logic rxOn;
    logic rxOff;
    logic rxRst;
    logic txOn;
    logic txOff;
    logic txRst;
    logic reqInt;
    logic ack;
    logic intMaskLoad;
    logic rdMaskLoad;
    logic filtLoad;
    logic [ARG_W-1:0] arg;
  } strobe_t;
endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
  import nic_cmd_pkg::*;
#(
  parameter int RESET_CYCLES = 1000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [OPC_W+ARG_W-1:0] cmdWord,
  output strobe_t                stb,
  output logic                   busy
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic [OPC_W-1:0] opc;
  logic             accept;
  logic             known;

  assign opc    = cmdWord[OPC_W+ARG_W-1:ARG_W];
  assign accept = cmdValid && !busy;
  assign busy   = (busyCnt != '0);

  always_comb begin
    stb     = '0;
    stb.arg = cmdWord[ARG_W-1:0];
    known   = 1'b1;
    case (opc)
      OP_GRESET:   stb.gReset      = accept;
      OP_WINDOW:   stb.winLoad     = accept;
      OP_RX_OFF:   stb.rxOff       = accept;
      OP_RX_ON:    stb.rxOn        = accept;
      OP_RX_RST:   stb.rxRst       = accept;
      OP_TX_ON:    stb.txOn        = accept;
      OP_TX_OFF:   stb.txOff       = accept;
      OP_TX_RST:   stb.txRst       = accept;
      OP_REQ_INT:  stb.reqInt      = accept;
      OP_ACK:      stb.ack         = accept;
      OP_INT_MASK: stb.intMaskLoad = accept;
      OP_RD_MASK:  stb.rdMaskLoad  = accept;
      OP_FILTER:   stb.filtLoad    = accept;
      default:     known           = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (accept && opc == OP_GRESET) begin
      busyCnt <= CNT_W'(RESET_CYCLES);
    end else if (accept && !known) begin
      busyCnt <= CNT_W'(1);
    end else if (busy) begin
      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  // R11: a global reset raises the busy flag on the next cycle
  a_r11_reset_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.gReset |=> busy);

  // R12: an accepted unknown opcode raises busy for one cycle
  a_r12_unknown_busy: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !known) |=> busy);

  // R12: no command strobe reaches the state while busy
  a_r12_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> $stable(busyCnt) || busyCnt == $past(busyCnt) - CNT_W'(1));
endmodule

// File: rtl/nic_cmd_state.sv
module nic_cmd_state
  import nic_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [CAUSE_W-1:0] causeIn,
  output logic [WIN_W-1:0]   window,
  output logic [CAUSE_W-1:0] latch,
  output logic [CAUSE_W-1:0] intMask,
  output logic [CAUSE_W-1:0] rdMask,
  output logic [FILT_W-1:0]  filter,
  output logic               rxEn,
  output logic               txEn,
  output logic               rxRstPulse,
  output logic               txRstPulse,
  output logic               gResetPulse
);
  logic [CAUSE_W-1:0] clrMask;
  logic [CAUSE_W-1:0] setMask;

  assign clrMask = (stb.ack || stb.gReset) ?
                   (stb.gReset ? {CAUSE_W{1'b1}} : stb.arg[CAUSE_W-1:0]) : '0;

  genvar gi;
  generate
    for (gi = 0; gi < CAUSE_W; gi++) begin : g_cause
      if (gi == REQ_BIT) begin : g_req
        assign setMask[gi] = causeIn[gi] | stb.reqInt;
      end else begin : g_plain
        assign setMask[gi] = causeIn[gi];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               latch[gi] <= 1'b0;
        else if (setMask[gi])    latch[gi] <= 1'b1;
        else if (clrMask[gi])    latch[gi] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window      <= '0;
      intMask     <= '0;
      rdMask      <= '1;
      filter      <= '0;
      rxEn        <= 1'b0;
      txEn        <= 1'b0;
      rxRstPulse  <= 1'b0;
      txRstPulse  <= 1'b0;
      gResetPulse <= 1'b0;
    end else begin
      rxRstPulse  <= stb.rxRst;
      txRstPulse  <= stb.txRst;
      gResetPulse <= stb.gReset;
      if (stb.gReset) begin
        window  <= '0;
        intMask <= '0;
        rdMask  <= '1;
        filter  <= '0;
        rxEn    <= 1'b0;
        txEn    <= 1'b0;
      end else begin
        if (stb.winLoad)     window  <= stb.arg[WIN_W-1:0];
        if (stb.intMaskLoad) intMask <= stb.arg[CAUSE_W-1:0];
        if (stb.rdMaskLoad)  rdMask  <= stb.arg[CAUSE_W-1:0];
        if (stb.filtLoad)    filter  <= stb.arg[FILT_W-1:0];
        if (stb.rxOn)                    rxEn <= 1'b1;
        else if (stb.rxOff || stb.rxRst) rxEn <= 1'b0;
        if (stb.txOn)                    txEn <= 1'b1;
        else if (stb.txOff || stb.txRst) txEn <= 1'b0;
      end
    end
  end

  // R3: every pulsed cause is latched on the next cycle
  a_r3_cause_sets: assert property (@(posedge clk) disable iff (!rstN)
    (causeIn != '0) |=> ((latch & $past(causeIn)) == $past(causeIn)));

  // R4: acknowledged bits without a simultaneous cause are clear afterwards
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> ((latch & $past(stb.arg[CAUSE_W-1:0] & ~causeIn)) == '0));

  // R9: the host request command sets cause bit 6
  a_r9_req_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.reqInt |=> latch[REQ_BIT]);

  // R7: the receiver reset pulse lasts one cycle
  a_r7_rx_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (rxRstPulse && !stb.rxRst) |=> !rxRstPulse);

  // R2: the window only moves on a select or a global reset
  a_r2_window_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.winLoad && !stb.gReset) |=> $stable(window));
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_cmd_pkg::*;
#(
  parameter int RESET_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdWord,
  input  logic [7:0]  causeIn,
  output logic [15:0] statusWord,
  output logic        intOut,
  output logic        rxEnabled,
  output logic        txEnabled,
  output logic        rxResetPulse,
  output logic        txResetPulse,
  output logic        globalResetPulse,
  output logic [3:0]  rxFilter
);
  strobe_t            stb;
  logic               busy;
  logic [WIN_W-1:0]   window;
  logic [CAUSE_W-1:0] latch;
  logic [CAUSE_W-1:0] intMask;
  logic [CAUSE_W-1:0] rdMask;

  nic_cmd_decode #(.RESET_CYCLES(RESET_CYCLES)) i_decode (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .stb      (stb),
    .busy     (busy)
  );

  nic_cmd_state i_state (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .causeIn     (causeIn),
    .window      (window),
    .latch       (latch),
    .intMask     (intMask),
    .rdMask      (rdMask),
    .filter      (rxFilter),
    .rxEn        (rxEnabled),
    .txEn        (txEnabled),
    .rxRstPulse  (rxResetPulse),
    .txRstPulse  (txResetPulse),
    .gResetPulse (globalResetPulse)
  );

  assign statusWord = {window, busy, 4'b0000, latch & rdMask};
  assign intOut     = |(latch & intMask);
endmodule

// File: tb/test_nic_cmd_ctrl.sv
module test_nic_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [7:0]  causeIn = '0;
  logic [15:0] statusWord;
  logic        intOut, rxEnabled, txEnabled;
  logic        rxResetPulse, txResetPulse, globalResetPulse;
  logic [3:0]  rxFilter;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [15:0] st;
    logic        io;
    logic [4:0]  ctl;
    logic [3:0]  filt;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  nic_cmd_ctrl #(.RESET_CYCLES(3)) i_nic_cmd_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .causeIn(causeIn), .statusWord(statusWord), .intOut(intOut),
    .rxEnabled(rxEnabled), .txEnabled(txEnabled),
    .rxResetPulse(rxResetPulse), .txResetPulse(txResetPulse),
    .globalResetPulse(globalResetPulse), .rxFilter(rxFilter)
  );

  // ctl = {globalResetPulse, rxEnabled, rxResetPulse, txEnabled, txResetPulse}
  task automatic step(input logic v, input logic [15:0] w, input logic [7:0] c,
                      input logic [15:0] st, input logic io, input logic [4:0] ctl,
                      input logic [3:0] f, input string tag);
    exp_t e;
    @(negedge clk);
    cmdValid = v; cmdWord = w; causeIn = c;
    e.st = st; e.io = io; e.ctl = ctl; e.filt = f; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [4:0] ctl;
        e = q.pop_front();
        ctl = {globalResetPulse, rxEnabled, rxResetPulse, txEnabled, txResetPulse};
        total++;
        if (statusWord !== e.st) begin
          bad++; $display("FAIL %s status actual=%h expected=%h", e.tag, statusWord, e.st);
        end
        total++;
        if (intOut !== e.io) begin
          bad++; $display("FAIL %s intOut actual=%b expected=%b", e.tag, intOut, e.io);
        end
        total++;
        if (ctl !== e.ctl) begin
          bad++; $display("FAIL %s ctl actual=%b expected=%b", e.tag, ctl, e.ctl);
        end
        total++;
        if (rxFilter !== e.filt) begin
          bad++; $display("FAIL %s filter actual=%h expected=%h", e.tag, rxFilter, e.filt);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 16'h0000, 8'h00, 16'h0000, 0, 5'b00000, 4'h0, "R1 reset state");
    step(1, 16'h0805, 8'h00, 16'hA000, 0, 5'b00000, 4'h0, "R2 window 5");
    step(0, 16'h0000, 8'h14, 16'hA014, 0, 5'b00000, 4'h0, "R3 causes 2,4");
    step(1, 16'h7004, 8'h00, 16'hA014, 1, 5'b00000, 4'h0, "R5 int mask 04");
    step(1, 16'h6804, 8'h00, 16'hA010, 0, 5'b00000, 4'h0, "R4 ack bit 2");
    step(1, 16'h780F, 8'h00, 16'hA000, 0, 5'b00000, 4'h0, "R6 read mask 0F");
    step(1, 16'h78FF, 8'h00, 16'hA010, 0, 5'b00000, 4'h0, "R6 read mask FF");
    step(1, 16'h2000, 8'h00, 16'hA010, 0, 5'b01000, 4'h0, "R7 rx on");
    step(1, 16'h4800, 8'h00, 16'hA010, 0, 5'b01010, 4'h0, "R8 tx on");
    step(1, 16'h2800, 8'h00, 16'hA010, 0, 5'b00110, 4'h0, "R7 rx reset");
    step(0, 16'h0000, 8'h00, 16'hA010, 0, 5'b00010, 4'h0, "R7 rx pulse ends");
    step(1, 16'h5000, 8'h00, 16'hA010, 0, 5'b00000, 4'h0, "R8 tx off");
    step(1, 16'h4800, 8'h00, 16'hA010, 0, 5'b00010, 4'h0, "R8 tx on again");
    step(1, 16'h5800, 8'h00, 16'hA010, 0, 5'b00001, 4'h0, "R8 tx reset");
    step(0, 16'h0000, 8'h00, 16'hA010, 0, 5'b00000, 4'h0, "R8 tx pulse ends");
    step(1, 16'h27FF, 8'h00, 16'hA010, 0, 5'b01000, 4'h0, "R7 rx on arg ignored");
    step(1, 16'h1FFF, 8'h00, 16'hA010, 0, 5'b00000, 4'h0, "R7 rx off arg ignored");
    step(1, 16'h6000, 8'h00, 16'hA050, 0, 5'b00000, 4'h0, "R9 request sets bit 6");
    step(1, 16'h7040, 8'h00, 16'hA050, 1, 5'b00000, 4'h0, "R5 mask bit 6");
    step(1, 16'h68FF, 8'h00, 16'hA000, 0, 5'b00000, 4'h0, "R4 ack all");
    step(1, 16'h6802, 8'h02, 16'hA002, 0, 5'b00000, 4'h0, "R4 set wins over ack");
    step(1, 16'h6802, 8'h00, 16'hA000, 0, 5'b00000, 4'h0, "R4 ack bit 1");
    step(1, 16'h800C, 8'h00, 16'hA000, 0, 5'b00000, 4'hC, "R10 filter C");
    step(1, 16'h80F5, 8'h00, 16'hA000, 0, 5'b00000, 4'h5, "R10 upper arg ignored");
    step(1, 16'h3800, 8'h00, 16'hB000, 0, 5'b00000, 4'h5, "R12 unknown busy");
    step(1, 16'h0802, 8'h00, 16'hA000, 0, 5'b00000, 4'h5, "R12 write while busy");
    step(0, 16'h0000, 8'h00, 16'hA000, 0, 5'b00000, 4'h5, "R12 window kept");
    step(0, 16'h0000, 8'h80, 16'hA080, 0, 5'b00000, 4'h5, "R3 cause 7");
    step(1, 16'h2000, 8'h00, 16'hA080, 0, 5'b01000, 4'h5, "R7 rx on before reset");
    step(1, 16'h0000, 8'h00, 16'h1000, 0, 5'b10000, 4'h0, "R11 global reset");
    step(1, 16'h0803, 8'h00, 16'h1000, 0, 5'b00000, 4'h0, "R11 busy drops write");
    step(0, 16'h0000, 8'h00, 16'h1000, 0, 5'b00000, 4'h0, "R11 busy third cycle");
    step(0, 16'h0000, 8'h00, 16'h0000, 0, 5'b00000, 4'h0, "R11 busy ends");
    step(0, 16'h0000, 8'h04, 16'h0004, 0, 5'b00000, 4'h0, "R11 masks reset");
    step(0, 16'h0000, 8'h00, 16'h0004, 0, 5'b00000, 4'h0, "R3 cause held");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule